// File: doc/BRIEF.md
# Dual Bidirectional GPIO Port

This block provides two general-purpose pin groups behind a small synchronous register bus: a 4-pin group A and an 8-pin group B. Each group holds an output data latch and a per-pin direction register. A direction bit of 1 turns the pin into an input and releases its driver. A direction bit of 0 enables the driver, which then drives the latched value. The pad cell sits outside the block. The block hands it a data value (`*_out`) and a drive enable (`*_oe`) for each pin, and it receives the level seen at the pad (`*_in`).

A read of a data register returns a mix per pin. Input pins return the pad level after a two-flop synchronizer. Output pins return their latch, even when something outside fights the driver. Because of this, firmware can do read-modify-write on a mixed-direction group without corrupting the latch bits of output pins. Writes always load the entire latch, input bits included, so a pin later switched to output drives the last value written to it. Reset makes every pin an input and leaves the latches as they were.

Top module: `gpio_dual_port`

## Requirements
- R1: The register bus uses a 2-bit address: 0 selects group A data, 1 selects group A direction, 2 selects group B data, and 3 selects group B direction. Write data bit i maps to pin i. A write takes place on the rising clock edge when `bus_we` is 1.
- R2: While reset is active and after it is released, every direction bit is 1, so all `*_oe` are 0. Direction reads then return 0x0F for A and 0xFF for B.
- R3: A pin whose direction bit is 0 has `oe` = 1 and drives its latch bit on `out`. A pin whose direction bit is 1 has `oe` = 0.
- R4: A direction register can be rewritten at any time. The new value appears on `oe` right after the write edge.
- R5: A data write loads every latch bit, including bits of input pins. A pin switched to output later drives the last value written.
- R6: A data read returns the pad level for an input pin through a two-flop synchronizer. A pad change made before edge k is read back after edge k+1, and not after edge k.
- R7: A data read returns the latch bit for an output pin, whatever level the pad shows.
- R8: Reads of either group A address return 0 in bits 7..4.
- R9: Reset leaves the output latches unchanged. A pin made an output after reset drives the value written before the reset.
- R10: A write to one register leaves the other three registers unchanged.
- R11: With `bus_we` at 0, no latch or direction bit changes, whatever address and data are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pa_in | input | 4 | Pad levels of group A |
| pa_out | output | 4 | Output data toward group A pads |
| pa_oe | output | 4 | Driver enables of group A |
| pb_in | input | 8 | Pad levels of group B |
| pb_out | output | 8 | Output data toward group B pads |
| pb_oe | output | 8 | Driver enables of group B |

## Verification
The hardest case to reach is the one where a pin's driver is enabled while the pad level disagrees with the latch. In that case the read must still show the latch. One cycle later, after a direction flip, it must show the synchronized pad level. The bench models the external world as free-running pad values that it scrambles at random while the random register traffic toggles direction bits. Contention on output pins therefore occurs constantly. Directed sequences add an explicit fight on group A, an edge-exact probe of the synchronizer delay on group B, and a reset in the middle of the run that must preserve the latches.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_A_DATA = 2'd0,
    REG_A_DIR  = 2'd1,
    REG_B_DATA = 2'd2,
    REG_B_DIR  = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stg_d;
      if (s == 0) begin : g_first
        always_comb stg_d = d;
      end else begin : g_next
        always_comb stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d;
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pin_rd,
  output logic [W-1:0] dir_rd
);
  logic [W-1:0] lat_q, lat_d;
  logic [W-1:0] dir_q, dir_d;
  logic [W-1:0] sync_val;

  // next state
  always_comb begin
    lat_d = wr_data ? wdata : lat_q;
    dir_d = wr_dir  ? wdata : dir_q;
  end

  // output latch: no reset, contents survive reset
  always_ff @(posedge clk) begin
    if (wr_data) lat_q <= lat_d;
  end

  // direction: reset to all inputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '1;
    else if (wr_dir) dir_q <= dir_d;
  end

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (sync_val)
  );

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pin
      assign pin_rd[i] = dir_q[i] ? sync_val[i] : lat_q[i];
      assign pad_oe[i] = ~dir_q[i];
    end
  endgenerate

  assign pad_out = lat_q;
  assign dir_rd  = dir_q;

  // checker state: edges seen since reset release (saturating)
  logic [1:0] prime_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              prime_q <= '0;
    else if (prime_q != 2'd2) prime_q <= prime_q + 2'd1;
  end

  AST_OUT_READS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_rd ^ pad_out) & pad_oe) == '0);  // R7

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data |=> $stable(pad_out));  // R11

  generate
    if (SYNC_STAGES == 2) begin : g_sync_chk
      AST_IN_READS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (prime_q == 2'd2) |-> (((pin_rd ^ $past(pad_in, 2)) & ~pad_oe) == '0));  // R6
    end
  endgenerate
endmodule

// File: rtl/gpio_dual_port.sv
module gpio_dual_port #(
  parameter int PA_W        = 4,
  parameter int PB_W        = 8,
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_we,
  input  logic [gpio_pkg::REG_ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]               bus_wdata,
  output logic [BUS_W-1:0]               bus_rdata,
  input  logic [PA_W-1:0]                pa_in,
  output logic [PA_W-1:0]                pa_out,
  output logic [PA_W-1:0]                pa_oe,
  input  logic [PB_W-1:0]                pb_in,
  output logic [PB_W-1:0]                pb_out,
  output logic [PB_W-1:0]                pb_oe
);
  import gpio_pkg::*;

  localparam int PA_PAD = BUS_W - PA_W;

  logic      rst_q;
  gpio_reg_e sel;
  logic      wr_a_data, wr_a_dir, wr_b_data, wr_b_dir;
  logic [PA_W-1:0] a_rd, a_dir;
  logic [PB_W-1:0] b_rd, b_dir;

  gpio_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_q)
  );

  assign sel = gpio_reg_e'(bus_addr);

  always_comb begin
    wr_a_data = bus_we && (sel == REG_A_DATA);
    wr_a_dir  = bus_we && (sel == REG_A_DIR);
    wr_b_data = bus_we && (sel == REG_B_DATA);
    wr_b_dir  = bus_we && (sel == REG_B_DIR);
  end

  gpio_port #(.W(PA_W), .SYNC_STAGES(SYNC_STAGES)) u_port_a (
    .clk     (clk),
    .rst_n   (rst_q),
    .wr_data (wr_a_data),
    .wr_dir  (wr_a_dir),
    .wdata   (bus_wdata[PA_W-1:0]),
    .pad_in  (pa_in),
    .pad_out (pa_out),
    .pad_oe  (pa_oe),
    .pin_rd  (a_rd),
    .dir_rd  (a_dir)
  );

  gpio_port #(.W(PB_W), .SYNC_STAGES(SYNC_STAGES)) u_port_b (
    .clk     (clk),
    .rst_n   (rst_q),
    .wr_data (wr_b_data),
    .wr_dir  (wr_b_dir),
    .wdata   (bus_wdata[PB_W-1:0]),
    .pad_in  (pb_in),
    .pad_out (pb_out),
    .pad_oe  (pb_oe),
    .pin_rd  (b_rd),
    .dir_rd  (b_dir)
  );

  always_comb begin
    unique case (sel)
      REG_A_DATA: bus_rdata = {{PA_PAD{1'b0}}, a_rd};
      REG_A_DIR:  bus_rdata = {{PA_PAD{1'b0}}, a_dir};
      REG_B_DATA: bus_rdata = b_rd;
      REG_B_DIR:  bus_rdata = b_dir;
      default:    bus_rdata = '0;
    endcase
  end

  AST_DIR_A_WRITE: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_we && sel == REG_A_DIR) |=> (pa_oe == ~$past(bus_wdata[PA_W-1:0])));  // R4

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    !bus_we |=> ($stable(pa_oe) && $stable(pb_oe)));  // R11

  AST_A_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_q)
    (sel == REG_A_DATA || sel == REG_A_DIR) |-> (bus_rdata[BUS_W-1:PA_W] == '0));  // R8

  AST_B_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_we && sel != REG_B_DATA) |=> $stable(pb_out));  // R10
endmodule

// File: tb/gpio_dual_port_tb_top.sv
`timescale 1ns/100ps
module gpio_dual_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [3:0] pa_in = 4'd0, pa_out, pa_oe;
  logic [7:0] pb_in = 8'd0, pb_out, pb_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_dual_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe)
  );

  // reference model, updated at each rising edge
  logic [1:0] m_rst;
  logic [3:0] m_lat_a, m_dir_a, m_s1_a, m_s2_a;
  logic [7:0] m_lat_b, m_dir_b, m_s1_b, m_s2_b;
  bit         m_known_a = 0, m_known_b = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rst = 2'b00; m_dir_a = 4'hF; m_dir_b = 8'hFF;
      m_s1_a = 0; m_s2_a = 0; m_s1_b = 0; m_s2_b = 0;
    end else begin
      if (m_rst[1]) begin
        if (bus_we) begin
          case (bus_addr)
            2'd0: begin m_lat_a = bus_wdata[3:0]; m_known_a = 1; end
            2'd1: m_dir_a = bus_wdata[3:0];
            2'd2: begin m_lat_b = bus_wdata; m_known_b = 1; end
            default: m_dir_b = bus_wdata;
          endcase
        end
        m_s2_a = m_s1_a; m_s1_a = pa_in;
        m_s2_b = m_s1_b; m_s1_b = pb_in;
      end
      m_rst = {m_rst[0], 1'b1};
    end
  end

  function automatic logic [7:0] exp_read(input logic [7:0] dir, input logic [7:0] lat,
                                          input logic [7:0] syn);
    return (dir & syn) | (~dir & lat);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // called just after a falling edge; uses the low half of the clock
  task automatic check_all();
    chk("R2 R3 R4 oe A", {4'h0, pa_oe}, {4'h0, ~m_dir_a});
    chk("R2 R3 R4 R10 oe B", pb_oe, ~m_dir_b);
    if (m_known_a) chk("R3 R5 out A", {4'h0, pa_out}, {4'h0, m_lat_a});
    if (m_known_b) chk("R3 R5 R10 out B", pb_out, m_lat_b);
    bus_addr = 2'd1; #0.5;
    chk("R1 R2 R8 dir A read", bus_rdata, {4'h0, m_dir_a});
    bus_addr = 2'd3; #0.5;
    chk("R1 R2 dir B read", bus_rdata, m_dir_b);
    if (m_known_a || m_dir_a == 4'hF) begin
      bus_addr = 2'd0; #0.5;
      chk("R6 R7 R8 data A read", bus_rdata,
          exp_read({4'hF, m_dir_a}, {4'h0, m_known_a ? m_lat_a : 4'h0}, {4'h0, m_s2_a}) & 8'h0F);
    end
    if (m_known_b || m_dir_b == 8'hFF) begin
      bus_addr = 2'd2; #0.5;
      chk("R6 R7 data B read", bus_rdata,
          exp_read(m_dir_b, m_known_b ? m_lat_b : 8'h0, m_s2_b));
    end
  endtask

  task automatic step(input logic we, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    check_all();
    bus_we = we; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 2'd0, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    // R2: all inputs during and after reset
    repeat (3) @(negedge clk);
    chk("R2 oe A in reset", {4'h0, pa_oe}, 8'h00);
    chk("R2 oe B in reset", pb_oe, 8'h00);
    rst_n = 1'b1;
    idle(4);

    // R5: latch loaded while pins are inputs, then driven after direction flip
    step(1'b1, 2'd0, 8'hF5);
    step(1'b1, 2'd2, 8'hA5);
    idle(2);
    chk("R5 oe A still off", {4'h0, pa_oe}, 8'h00);
    step(1'b1, 2'd1, 8'h00);
    step(1'b0, 2'd0, 8'h00);
    chk("R4 R5 A drives 5", {4'h0, pa_out & pa_oe}, 8'h05);

    // R7: contention on group A outputs
    pa_in = 4'hA;
    idle(3);
    bus_addr = 2'd0; #0.5;
    chk("R7 contention read A", bus_rdata, 8'h05);

    // R6: edge-exact synchronizer delay on group B (inputs)
    pb_in = 8'h3C;
    idle(3);
    @(negedge clk);
    pb_in = 8'hC3;
    @(negedge clk); bus_addr = 2'd2; #0.5;
    chk("R6 one edge: old value", bus_rdata, 8'h3C);
    @(negedge clk); #0.5;
    chk("R6 two edges: new value", bus_rdata, 8'hC3);

    // R10: write A data, B unchanged; R11: no write with we low
    step(1'b1, 2'd0, 8'h0A);
    step(1'b0, 2'd2, 8'h00);
    step(1'b0, 2'd3, 8'h00);
    idle(1);
    chk("R10 B latch kept", pb_out, 8'hA5);
    chk("R11 B dir kept", pb_oe, 8'h00);

    // R9: reset keeps latches
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R2 R9 oe A cleared by reset", {4'h0, pa_oe}, 8'h00);
    rst_n = 1'b1;
    idle(3);
    step(1'b1, 2'd3, 8'h00);
    idle(1);
    chk("R9 B latch survives reset", pb_out & pb_oe, 8'hA5);

    // random phase
    for (int it = 0; it < 3000; it++) begin
      int unsigned op = $urandom_range(0, 3);
      if (op == 1) begin
        pa_in = 4'($urandom); pb_in = 8'($urandom);
        step(1'b0, 2'($urandom), 8'($urandom));
      end else if (op == 2) begin
        step(1'b0, 2'($urandom), 8'($urandom));
      end else begin
        step(1'b1, 2'($urandom), 8'($urandom));
      end
    end
    idle(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule